// File: doc/BRIEF.md
# Host-Port Source Tag Appender

This block sits on the transmit path from a small multiport switch toward an attached host processor. Each frame bound for the host arrives as a ready/valid byte stream with an end-of-frame marker, and with the number of the switch port it came in on. When tagging is enabled, the block adds one extra byte after the last data byte. That byte tells the host which of the four external ports sent the frame. The end-of-frame marker moves onto this new byte.

When tagging is disabled, frames pass through unchanged. The enable and the source port are captured on the first byte of each frame, so a change while a frame is in flight does not affect that frame. While the tag byte is waiting to be accepted, the input is held off. The data path adds no register: bytes pass through combinationally, and only the tag byte comes from state.

Top module: `tail_tag_inserter`

## Requirements
- R1: With tagging enabled, every frame byte appears on the output unchanged and in order, and the original last byte leaves with `m_last` low.
- R2: With tagging enabled, the output beat right after the original last byte is one extra byte with `m_last` high. Its bits [1:0] carry the source code: 0, 1, 2 and 3 stand for ports 1, 2, 3 and 4.
- R3: Bits [7:2] of the tag byte are zero.
- R4: With tagging disabled, a frame leaves exactly as it entered. `m_last` is on the original last byte and no extra byte follows.
- R5: While the tag byte is pending, `s_ready` is low. The next frame's first byte is accepted only after the tag has been accepted.
- R6: `s_src_port` is sampled on the first byte of a frame. Changes to it later in the same frame do not alter that frame's tag.
- R7: `tag_enable` is sampled on the first byte of a frame. A change during the frame takes effect from the next frame.
- R8: While `m_ready` is low, a pending tag beat stays valid with stable data and `m_last`.
- R9: After reset no tag is pending: with `s_valid` low, `m_valid` is low and `s_ready` follows `m_ready`.
- R10: A one-byte frame with tagging enabled leaves as two beats: the data byte and then its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tag_enable | input | 1 | Tagging enable, sampled per frame |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted when high with s_valid |
| s_data | input | 8 | Input frame byte |
| s_last | input | 1 | Input byte ends the frame |
| s_src_port | input | 2 | Ingress port code, 0..3 for ports 1..4 |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Host side accepts the byte |
| m_data | output | 8 | Output byte |
| m_last | output | 1 | Output byte ends the frame |

## Verification
The assertions assume a well-behaved upstream. A byte offered on `s_valid` is held with the same data and `s_last` until it is accepted, and every frame ends with `s_last`. The stall and tag-follow properties depend on this. The bench driver keeps `s_valid` and the byte steady until it sees a handshake. It changes `s_src_port` and `tag_enable` only in the middle of frames, where R6 and R7 require those changes to be ignored. `m_ready` is toggled freely, because the block must handle any host back-pressure.

// File: rtl/ttag_pkg.sv
// Package: widths and tag construction shared by the tag appender blocks.
// Assumes the tag is one byte and the source field sits in its low bits.
package ttag_pkg;
    localparam int unsigned TAG_BYTE_W = 8;
    localparam int unsigned SRC_CODE_W = 2;

    // Build a tag byte: source code in the low bits, all other bits zero.
    function automatic logic [TAG_BYTE_W-1:0] make_tag(input logic [SRC_CODE_W-1:0] src);
        logic [TAG_BYTE_W-1:0] t;
        t = '0;
        t[SRC_CODE_W-1:0] = src;
        return t;
    endfunction
endpackage

// File: rtl/ttag_frame_ctx.sv
// Frame context: tracks whether a frame is in flight and holds the source code
// and enable captured on its first byte. Assumes every frame ends with a last byte.
module ttag_frame_ctx #(
    parameter int unsigned SRC_W = ttag_pkg::SRC_CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_acc,
    input  logic             beat_last,
    input  logic [SRC_W-1:0] src_in,
    input  logic             en_in,
    output logic [SRC_W-1:0] eff_src,
    output logic             eff_en
);
    logic             mid_frame;
    logic [SRC_W-1:0] held_src;
    logic             held_en;

    // Mark frame in flight after a non-last byte; clear on the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mid_frame <= 1'b0;
        else if (beat_acc)
            mid_frame <= !beat_last;
    end

    // Capture source and enable on the first byte of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_src <= '0;
            held_en  <= 1'b0;
        end else if (beat_acc && !mid_frame) begin
            held_src <= src_in;
            held_en  <= en_in;
        end
    end

    // Use live values on the first byte, captured values afterwards.
    always_comb begin
        eff_src = mid_frame ? held_src : src_in;
        eff_en  = mid_frame ? held_en  : en_in;
    end

    // Captured values stay fixed while a frame is in flight.
    assert_ctx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_frame && $past(rst_n) && $past(mid_frame)) |-> ($stable(held_src) && $stable(held_en)));
endmodule

// File: rtl/ttag_tag_gen.sv
// Tag generator: after an enabled frame's last byte is accepted, holds the tag
// byte pending until the host side accepts it. Assumes tag_acc only while pending.
module ttag_tag_gen #(
    parameter int unsigned DATA_W = ttag_pkg::TAG_BYTE_W,
    parameter int unsigned SRC_W  = ttag_pkg::SRC_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_acc,
    input  logic              beat_last,
    input  logic              eff_en,
    input  logic [SRC_W-1:0]  eff_src,
    input  logic              tag_acc,
    output logic              tag_pending,
    output logic [DATA_W-1:0] tag_byte
);
    // Raise pending on an enabled last byte; drop it when the tag is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tag_pending <= 1'b0;
        else if (beat_acc && beat_last && eff_en)
            tag_pending <= 1'b1;
        else if (tag_acc)
            tag_pending <= 1'b0;
    end

    // Latch the tag contents together with the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tag_byte <= '0;
        else if (beat_acc && beat_last && eff_en)
            tag_byte <= ttag_pkg::make_tag(eff_src);
    end

    // No input byte may be accepted while a tag is pending.
    assert_no_beat_while_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tag_pending |-> !beat_acc);
    // Tag contents are stable while pending and not accepted.
    assert_tag_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_pending && !tag_acc) |=> (tag_pending && $stable(tag_byte)));
endmodule

// File: rtl/ttag_out_mux.sv
// Output selector: passes input bytes through or presents the pending tag.
// Purely combinational; assumes tag_pending comes from a register.
module ttag_out_mux #(
    parameter int unsigned DATA_W = ttag_pkg::TAG_BYTE_W
) (
    input  logic              tag_pending,
    input  logic [DATA_W-1:0] tag_byte,
    input  logic              eff_en,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    input  logic              m_ready,
    output logic              s_ready,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last
);
    // Select between the tag beat and the pass-through beat.
    always_comb begin
        s_ready = m_ready && !tag_pending;
        m_valid = tag_pending || s_valid;
        m_data  = tag_pending ? tag_byte : s_data;
        m_last  = tag_pending || (s_last && !eff_en);
    end
endmodule

// File: rtl/tail_tag_inserter.sv
// Top: appends a one-byte source-port tag after each host-bound frame when
// enabled. Assumes the upstream holds a byte stable until it is accepted.
module tail_tag_inserter #(
    parameter int unsigned DATA_W = ttag_pkg::TAG_BYTE_W,
    parameter int unsigned SRC_W  = ttag_pkg::SRC_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tag_enable,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    input  logic [SRC_W-1:0]  s_src_port,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last
);
    localparam int unsigned PAD_W = DATA_W - SRC_W;

    logic              beat_acc, tag_acc, tag_pending, eff_en;
    logic [SRC_W-1:0]  eff_src;
    logic [DATA_W-1:0] tag_byte;

    // Handshake decode for input bytes and the tag beat.
    always_comb begin
        beat_acc = s_valid && s_ready;
        tag_acc  = tag_pending && m_ready;
    end

    ttag_frame_ctx #(.SRC_W(SRC_W)) u_ctx (
        .clk(clk), .rst_n(rst_n), .beat_acc(beat_acc), .beat_last(s_last),
        .src_in(s_src_port), .en_in(tag_enable), .eff_src(eff_src), .eff_en(eff_en));

    ttag_tag_gen #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_tag (
        .clk(clk), .rst_n(rst_n), .beat_acc(beat_acc), .beat_last(s_last),
        .eff_en(eff_en), .eff_src(eff_src), .tag_acc(tag_acc),
        .tag_pending(tag_pending), .tag_byte(tag_byte));

    ttag_out_mux #(.DATA_W(DATA_W)) u_mux (
        .tag_pending(tag_pending), .tag_byte(tag_byte), .eff_en(eff_en),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .m_ready(m_ready),
        .s_ready(s_ready), .m_valid(m_valid), .m_data(m_data), .m_last(m_last));

    // An enabled last byte is followed by a last-marked beat carrying the source.
    assert_tag_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_acc && s_last && eff_en) |=>
            (m_valid && m_last && !s_ready && m_data[SRC_W-1:0] == $past(eff_src)));
    // Upper tag bits are zero.
    assert_tag_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_acc && s_last && eff_en) |=> (m_data[DATA_W-1:SRC_W] == {PAD_W{1'b0}}));
    // The original last byte carries no end marker when tagging is on.
    assert_orig_last_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_acc && s_last && eff_en) |-> !m_last);
    // A disabled frame ends on its own last byte with no tag pending after it.
    assert_no_tag_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_acc && s_last && !eff_en) |=> s_ready == m_ready);
endmodule

// File: tb/test_tail_tag_inserter.sv
module test_tail_tag_inserter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tag_enable = 1'b0;
    logic       s_valid = 1'b0;
    logic       s_ready;
    logic [7:0] s_data = '0;
    logic       s_last = 1'b0;
    logic [1:0] s_src_port = '0;
    logic       m_valid;
    logic       m_ready = 1'b0;
    logic [7:0] m_data;
    logic       m_last;

    int checks = 0;
    int errors = 0;
    logic [8:0] exp_q[$];
    string      req_q[$];
    bit         tag_q[$];
    bit         random_ready = 1'b0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    tail_tag_inserter i_tail_tag_inserter (
        .clk(clk), .rst_n(rst_n), .tag_enable(tag_enable),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .s_src_port(s_src_port), .m_valid(m_valid), .m_ready(m_ready),
        .m_data(m_data), .m_last(m_last));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one byte and hold it until it is accepted.
    task automatic drive_byte(input logic [7:0] d, input bit last);
        s_valid = 1'b1; s_data = d; s_last = last;
        @(negedge clk);
        while (!s_ready) @(negedge clk);
        @(posedge clk); #1;
        s_valid = 1'b0;
    endtask

    // Send a frame; push expected beats; optionally disturb src/enable mid-frame.
    task automatic send_frame(input int len, input logic [1:0] src, input bit en,
                              input logic [7:0] seed, input bit disturb, input string req);
        tag_enable = en; s_src_port = src;
        for (int i = 0; i < len; i++) begin
            exp_q.push_back({(i == len-1) && !en, seed + 8'(i)});
            req_q.push_back(en ? "R1" : "R4");
            tag_q.push_back(1'b0);
        end
        if (en) begin
            exp_q.push_back({1'b1, 6'b0, src});
            req_q.push_back(req);
            tag_q.push_back(1'b1);
        end
        for (int i = 0; i < len; i++) begin
            drive_byte(seed + 8'(i), i == len-1);
            if (disturb && i == 0) begin
                s_src_port = ~src;
                tag_enable = ~en;
            end
        end
    endtask

    // Host-side readiness: always ready or pseudo-random.
    always @(posedge clk) begin
        #1;
        m_ready <= random_ready ? ($urandom_range(3) != 0) : 1'b1;
    end

    // Monitor: compares handshaken output beats against the scoreboard.
    logic       prev_stall = 1'b0;
    logic [8:0] prev_beat = '0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (prev_stall)
                check(m_valid && {m_last, m_data} == prev_beat, "R8",
                      {m_valid, m_last, m_data}, {1'b1, prev_beat});
            if (tag_q.size() > 0 && tag_q[0] && m_valid)
                check(!s_ready, "R5", s_ready, 0);
            if (m_valid && m_ready) begin
                if (exp_q.size() == 0)
                    check(1'b0, "R4", {m_last, m_data}, 0);
                else begin
                    logic [8:0] e;
                    string r;
                    e = exp_q.pop_front(); r = req_q.pop_front(); void'(tag_q.pop_front());
                    check({m_last, m_data} == e, r, {m_last, m_data}, e);
                end
            end
            prev_stall = m_valid && !m_ready && tag_q.size() > 0 && tag_q[0];
            prev_beat  = {m_last, m_data};
        end
    end

    initial begin
        fork
            begin
                repeat (199000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        join_none
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!m_valid && s_ready == m_ready, "R9", {m_valid, s_ready}, {1'b0, m_ready});
        @(posedge clk); #1;
        // Tagged frames from each source port.
        send_frame(4, 2'd0, 1'b1, 8'h10, 1'b0, "R2");
        send_frame(3, 2'd1, 1'b1, 8'h20, 1'b0, "R2");
        send_frame(5, 2'd2, 1'b1, 8'h30, 1'b0, "R3");
        send_frame(2, 2'd3, 1'b1, 8'h40, 1'b0, "R3");
        // Untagged frames.
        send_frame(3, 2'd2, 1'b0, 8'h50, 1'b0, "R4");
        // Single-byte frames.
        send_frame(1, 2'd1, 1'b1, 8'h60, 1'b0, "R10");
        send_frame(1, 2'd3, 1'b0, 8'h61, 1'b0, "R4");
        // Mid-frame changes of source and enable are ignored.
        send_frame(4, 2'd1, 1'b1, 8'h70, 1'b1, "R6");
        send_frame(4, 2'd2, 1'b0, 8'h80, 1'b1, "R7");
        send_frame(2, 2'd0, 1'b1, 8'h90, 1'b0, "R7");
        // Host back-pressure.
        random_ready = 1'b1;
        for (int f = 0; f < 30; f++)
            send_frame(1 + (f % 5), 2'(f), (f % 3) != 0, 8'(f * 7), f[0], "R8");
        random_ready = 1'b0;
        repeat (20) @(posedge clk);
        done = 1'b1;
        check(exp_q.size() == 0, "R2", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule